// File: doc/BRIEF.md
# Cross-Domain Command Event Synchronizer

This block turns a write to one chosen register on an external, strobe-clocked bus into a clean one-cycle event in the main system clock domain. The bus side has no free-running clock. Its command strobe is the only timing reference, so every rising edge of that strobe acts as the clock for the source domain.

On each command edge the block captures the raw qualifiers: operation active, the write strobe and the register address. On the next command edge it registers the decoded event bit, which is the AND of those captured qualifiers. That single registered bit is the only signal that crosses into the main domain. It goes straight into a chain of synchronizer flops with no gate in front. A final flop in the main domain holds the previous synchronized value, and the output pulse marks a rising transition.

The address compare is never exposed to the other domain as raw combinational logic. Its unequal settling times therefore cannot produce a short false high that the main domain might catch.

Top module: `cmd_event_sync`

## Requirements
- R1: The source event bit is set only when the captured operation-active flag is 1, the captured write strobe is 0 (active low, default `WR_ACTIVE_LOW=1`), and the captured address equals `EVENT_ADDR` (default 4'hA).
- R2: Raw bus inputs are sampled only on the rising edge of `bus_cmd`. A matching pattern that appears and goes away between two command edges produces no pulse.
- R3: The event bit for a transaction captured on command edge k is registered on command edge k+1. The main domain cannot see a transaction before that second edge.
- R4: When the address moves from `EVENT_ADDR` to another register while operation-active stays 1 and the write strobe stays 0, no extra pulse is produced.
- R5: Each rising transition of the source event bit gives exactly one `evt_pulse` that is high for exactly one `sys_clk` cycle.
- R6: Back-to-back matching writes that keep the event bit high produce no further pulses.
- R7: With the command strobe held steady, `evt_pulse` rises within `SYNC_STAGES+2` `sys_clk` cycles of the command edge that raises the event bit.
- R8: A low `bus_rst_n` on a command edge clears the capture and event flops. A low `sys_rst_n` on a `sys_clk` edge clears the synchronizer and edge flops and holds `evt_pulse` low.
- R9: A transaction with operation-active 0, write strobe 1, or a non-matching address gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_cmd | input | 1 | Bus command strobe; its rising edge clocks the source domain |
| bus_rst_n | input | 1 | Active-low reset, synchronous to `bus_cmd` |
| bus_op_active | input | 1 | Raw operation-active qualifier |
| bus_wr_n | input | 1 | Raw write strobe (polarity set by `WR_ACTIVE_LOW`) |
| bus_addr | input | ADDR_W | Raw register address |
| sys_clk | input | 1 | Main system clock |
| sys_rst_n | input | 1 | Active-low reset, synchronous to `sys_clk` |
| evt_pulse | output | 1 | One-cycle event pulse in the `sys_clk` domain |

## Verification
The hardest case to reach from the ports is the one the block exists to prevent. The address leaves the event register while both qualifiers stay true, so a raw decode could briefly read as true. The stimulus table therefore places a matching write directly before a write to another address with the same qualifiers, and it checks that this sequence adds no pulse. Because the source pipeline is two command edges deep, every expected count in the table looks two entries back. A separate sequence raises a matching pattern between strobes to show that only edge-time values count.

// File: rtl/cmd_evt_pkg.sv
package cmd_evt_pkg;
   localparam int MIN_SYNC_STAGES = 2;
   localparam int MAX_SYNC_STAGES = 8;

   typedef struct packed {
      logic op;
      logic wr;
   } cmd_qual_t;
endpackage

// File: rtl/cmd_evt_capture.sv
module cmd_evt_capture #(
   parameter int ADDR_W = 4
) (
   input  logic              cmd_clk,
   input  logic              cmd_rst_n,
   input  logic              raw_op,
   input  logic              raw_wr,
   input  logic [ADDR_W-1:0] raw_addr,
   output cmd_evt_pkg::cmd_qual_t cap_qual,
   output logic [ADDR_W-1:0] cap_addr
);
   always_ff @(posedge cmd_clk) begin
      if (!cmd_rst_n) begin
         cap_qual <= '0;
         cap_addr <= '0;
      end else begin
         cap_qual.op <= raw_op;
         cap_qual.wr <= raw_wr;
         cap_addr    <= raw_addr;
      end
   end
endmodule

// File: rtl/cmd_evt_decode_reg.sv
module cmd_evt_decode_reg #(
   parameter int              ADDR_W        = 4,
   parameter logic [ADDR_W-1:0] EVENT_ADDR  = 4'hA,
   parameter bit              WR_ACTIVE_LOW = 1'b1
) (
   input  logic              cmd_clk,
   input  logic              cmd_rst_n,
   input  cmd_evt_pkg::cmd_qual_t cap_qual,
   input  logic [ADDR_W-1:0] cap_addr,
   output logic              evt_q
);
   logic wr_hit;
   logic addr_hit;

   generate
      if (WR_ACTIVE_LOW) begin : g_wr_low
         assign wr_hit = ~cap_qual.wr;
      end else begin : g_wr_high
         assign wr_hit = cap_qual.wr;
      end
   endgenerate

   assign addr_hit = (cap_addr == EVENT_ADDR);

   // the full decode settles here, inside the strobe domain
   always_ff @(posedge cmd_clk) begin
      if (!cmd_rst_n) evt_q <= 1'b0;
      else            evt_q <= cap_qual.op & wr_hit & addr_hit;
   end
endmodule

// File: rtl/cmd_evt_sync.sv
module cmd_evt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < cmd_evt_pkg::MIN_SYNC_STAGES || STAGES > cmd_evt_pkg::MAX_SYNC_STAGES) begin : g_bad
         $error("cmd_evt_sync: STAGES out of range");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cmd_evt_edge.sv
module cmd_evt_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic prev_q,
   output logic rise_pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_in;
   end

   assign rise_pulse = level_in & ~prev_q;
endmodule

// File: rtl/cmd_event_sync.sv
module cmd_event_sync #(
   parameter int                ADDR_W        = 4,
   parameter logic [ADDR_W-1:0] EVENT_ADDR    = 4'hA,
   parameter bit                WR_ACTIVE_LOW = 1'b1,
   parameter int                SYNC_STAGES   = 2
) (
   input  logic              bus_cmd,
   input  logic              bus_rst_n,
   input  logic              bus_op_active,
   input  logic              bus_wr_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              sys_clk,
   input  logic              sys_rst_n,
   output logic              evt_pulse
);
   generate
      if (ADDR_W < 1) begin : g_bad_w
         $error("cmd_event_sync: ADDR_W must be positive");
      end
   endgenerate

   cmd_evt_pkg::cmd_qual_t cap_qual;
   logic              cap_op;
   logic              cap_wr_n;
   logic [ADDR_W-1:0] cap_addr;
   logic              evt_src;
   logic              sync_last;
   logic              edge_q;

   assign cap_op   = cap_qual.op;
   assign cap_wr_n = cap_qual.wr;

   cmd_evt_capture #(.ADDR_W(ADDR_W)) u_cap (
      .cmd_clk   (bus_cmd),
      .cmd_rst_n (bus_rst_n),
      .raw_op    (bus_op_active),
      .raw_wr    (bus_wr_n),
      .raw_addr  (bus_addr),
      .cap_qual  (cap_qual),
      .cap_addr  (cap_addr)
   );

   cmd_evt_decode_reg #(
      .ADDR_W        (ADDR_W),
      .EVENT_ADDR    (EVENT_ADDR),
      .WR_ACTIVE_LOW (WR_ACTIVE_LOW)
   ) u_dec (
      .cmd_clk   (bus_cmd),
      .cmd_rst_n (bus_rst_n),
      .cap_qual  (cap_qual),
      .cap_addr  (cap_addr),
      .evt_q     (evt_src)
   );

   // evt_src feeds the first sync flop with nothing in between
   cmd_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (sys_clk),
      .rst_n    (sys_rst_n),
      .async_in (evt_src),
      .sync_out (sync_last)
   );

   cmd_evt_edge u_edge (
      .clk        (sys_clk),
      .rst_n      (sys_rst_n),
      .level_in   (sync_last),
      .prev_q     (edge_q),
      .rise_pulse (evt_pulse)
   );
endmodule

// File: rtl/cmd_event_sync_chk.sv
module cmd_event_sync_chk #(
   parameter int                ADDR_W        = 4,
   parameter logic [ADDR_W-1:0] EVENT_ADDR    = 4'hA,
   parameter bit                WR_ACTIVE_LOW = 1'b1
) (
   input logic              bus_cmd,
   input logic              bus_rst_n,
   input logic              sys_clk,
   input logic              sys_rst_n,
   input logic              cap_op,
   input logic              cap_wr_n,
   input logic [ADDR_W-1:0] cap_addr,
   input logic              evt_src,
   input logic              edge_q,
   input logic              evt_pulse
);
   a_r1_rise_needs_match: assert property (@(posedge bus_cmd) disable iff (!bus_rst_n)
      $rose(evt_src) |-> ($past(cap_op) && ($past(cap_wr_n) != WR_ACTIVE_LOW)
                          && ($past(cap_addr) == EVENT_ADDR)))
      else $error("a_r1_rise_needs_match");

   a_r8_src_reset: assert property (@(posedge bus_cmd)
      !bus_rst_n |=> !evt_src)
      else $error("a_r8_src_reset");

   a_r5_one_cycle: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      evt_pulse |=> !evt_pulse)
      else $error("a_r5_one_cycle");

   a_r5_edge_arms: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      evt_pulse |=> edge_q)
      else $error("a_r5_edge_arms");

   a_r8_sys_reset: assert property (@(posedge sys_clk)
      !sys_rst_n |=> (!evt_pulse && !edge_q))
      else $error("a_r8_sys_reset");
endmodule

bind cmd_event_sync cmd_event_sync_chk #(
   .ADDR_W        (ADDR_W),
   .EVENT_ADDR    (EVENT_ADDR),
   .WR_ACTIVE_LOW (WR_ACTIVE_LOW)
) u_chk (
   .bus_cmd   (bus_cmd),
   .bus_rst_n (bus_rst_n),
   .sys_clk   (sys_clk),
   .sys_rst_n (sys_rst_n),
   .cap_op    (cap_op),
   .cap_wr_n  (cap_wr_n),
   .cap_addr  (cap_addr),
   .evt_src   (evt_src),
   .edge_q    (edge_q),
   .evt_pulse (evt_pulse)
);

// File: tb/cmd_event_sync_test.sv
module cmd_event_sync_test;
   localparam int  ADDR_W = 4;
   localparam logic [3:0] EV = 4'hA;
   localparam int  SYNC_STAGES = 2;

   typedef struct packed {
      logic       op;
      logic       wr_n;
      logic [3:0] addr;
      logic       exp;
   } vec_t;

   // exp = decode(entry k-1) and not decode(entry k-2)
   localparam vec_t VEC [0:14] = '{
      '{1'b1, 1'b0, 4'hA, 1'b0},
      '{1'b1, 1'b0, 4'h3, 1'b1},
      '{1'b1, 1'b0, 4'hA, 1'b0},
      '{1'b1, 1'b0, 4'hA, 1'b1},
      '{1'b1, 1'b0, 4'h5, 1'b0},
      '{1'b1, 1'b0, 4'h5, 1'b0},
      '{1'b0, 1'b0, 4'hA, 1'b0},
      '{1'b1, 1'b1, 4'hA, 1'b0},
      '{1'b1, 1'b0, 4'hA, 1'b0},
      '{1'b1, 1'b0, 4'hB, 1'b1},
      '{1'b1, 1'b0, 4'hA, 1'b0},
      '{1'b1, 1'b0, 4'hA, 1'b1},
      '{1'b1, 1'b0, 4'hA, 1'b0},
      '{1'b1, 1'b0, 4'h0, 1'b0},
      '{1'b0, 1'b1, 4'h0, 1'b0}
   };

   logic       bus_cmd = 1'b0;
   logic       bus_rst_n = 1'b0;
   logic       bus_op_active = 1'b0;
   logic       bus_wr_n = 1'b1;
   logic [3:0] bus_addr = '0;
   logic       sys_clk = 1'b0;
   logic       sys_rst_n = 1'b0;
   logic       evt_pulse;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   int  tot_rise = 0;
   int  tot_high = 0;
   logic prev_p = 1'b0;
   realtime last_rise_t = 0.0;

   int      rises, highs;
   realtime lat;

   always #2 sys_clk = ~sys_clk;

   cmd_event_sync #(
      .ADDR_W(ADDR_W), .EVENT_ADDR(EV), .WR_ACTIVE_LOW(1'b1), .SYNC_STAGES(SYNC_STAGES)
   ) uut (
      .bus_cmd(bus_cmd), .bus_rst_n(bus_rst_n), .bus_op_active(bus_op_active),
      .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .sys_clk(sys_clk),
      .sys_rst_n(sys_rst_n), .evt_pulse(evt_pulse)
   );

   always @(negedge sys_clk) begin
      if (evt_pulse === 1'b1) begin
         tot_high = tot_high + 1;
         if (prev_p !== 1'b1) begin
            tot_rise = tot_rise + 1;
            last_rise_t = $realtime;
         end
      end
      prev_p = evt_pulse;
   end

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic cmd_edge(input logic op, input logic wr, input logic [3:0] a);
      int r0, h0;
      realtime t0;
      bus_op_active = op;
      bus_wr_n      = wr;
      bus_addr      = a;
      #3;
      r0 = tot_rise;
      h0 = tot_high;
      t0 = $realtime;
      bus_cmd = 1'b1;
      #24;
      bus_cmd = 1'b0;
      #36;
      rises = tot_rise - r0;
      highs = tot_high - h0;
      lat   = (rises > 0) ? (last_rise_t - t0) : 0.0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // reset state (R8)
      cmd_edge(1'b1, 1'b0, EV);
      cmd_edge(1'b1, 1'b0, EV);
      @(negedge sys_clk);
      check("R8 pulse low in reset", evt_pulse, 0);
      check("R8 no pulse during reset", tot_rise, 0);
      bus_rst_n = 1'b1;
      @(negedge sys_clk);
      sys_rst_n = 1'b1;
      repeat (4) @(negedge sys_clk);

      // stimulus table: R1 R3 R4 R6 R9, pulse width R5
      foreach (VEC[i]) begin
         cmd_edge(VEC[i].op, VEC[i].wr_n, VEC[i].addr);
         check($sformatf("R1 R3 R4 R6 R9 table entry %0d pulses", i), rises, int'(VEC[i].exp));
         check($sformatf("R5 table entry %0d width", i), highs, rises);
      end

      // R2: matching pattern between strobes is ignored
      bus_op_active = 1'b1; bus_wr_n = 1'b0; bus_addr = EV;
      #40;
      bus_op_active = 1'b0; bus_wr_n = 1'b1; bus_addr = 4'h1;
      #10;
      cmd_edge(1'b0, 1'b1, 4'h1);
      check("R2 between-strobe pattern edge 1", rises, 0);
      cmd_edge(1'b0, 1'b1, 4'h1);
      check("R2 between-strobe pattern edge 2", rises, 0);

      // R3/R7: capture edge gives nothing, next edge raises pulse within bound
      cmd_edge(1'b1, 1'b0, EV);
      check("R3 no pulse on capture edge", rises, 0);
      cmd_edge(1'b0, 1'b1, 4'h2);
      check("R3 pulse on following edge", rises, 1);
      check("R7 latency bound", (lat <= (SYNC_STAGES + 2) * 4.0) ? 1 : 0, 1);
      check("R5 width after latency test", highs, 1);

      // R8: source reset clears a high event bit
      bus_rst_n = 1'b0;
      cmd_edge(1'b1, 1'b0, EV);
      check("R8 source reset gives no pulse", rises, 0);
      bus_rst_n = 1'b1;
      cmd_edge(1'b1, 1'b0, EV);
      check("R8 event cleared by source reset", rises, 0);
      cmd_edge(1'b0, 1'b1, 4'h0);
      check("R8 re-fires after source reset", rises, 1);

      // R8: system reset holds pulse low
      sys_rst_n = 1'b0;
      cmd_edge(1'b1, 1'b0, EV);
      cmd_edge(1'b0, 1'b1, 4'h0);
      check("R8 no pulse under system reset", rises, 0);
      cmd_edge(1'b0, 1'b1, 4'h0);
      cmd_edge(1'b0, 1'b1, 4'h0);
      sys_rst_n = 1'b1;
      repeat (8) @(negedge sys_clk);
      check("R8 pulse low after system reset", evt_pulse, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule